// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair with Acknowledge and Vector Output

This block combines two eight-line priority interrupt controllers into one sixteen-line unit. The upstream controller ("master") takes lines 0 to 7 and reports to the processor. The downstream controller ("slave") takes lines 8 to 15, and its request output drives master line 2. A processor acknowledge strobe selects the winning line at both levels, moves it into service and returns an 8-bit vector in the same cycle. If no line qualifies at either level, a substitute vector is returned.

Software reaches the block through a byte-wide read/write bus. Each controller has an even (command) port and an odd (data) port. Two more ports hold each controller's trigger-mode setting. A poll command turns the next read of that controller into a status byte, and that read also takes the winning request. Reads return data combinationally while the read strobe is high. Every state change happens on the following clock edge.

Top module: `pic_cascade_unit`

## Requirements
- R1: After reset, int_out is 0. All request, in-service, mask and trigger-mode registers read 0, and both vector bases are 0.
- R2: On an edge-triggered line, a rising input sets its request bit at the next clock edge. Acknowledging or polling that line clears the bit, and it is not set again until the input has gone low and high once more.
- R3: Trigger-mode registers sit at 0x4D0 (master, writable bits 0xF8) and 0x4D1 (slave, writable bits 0xDE), and they read back the stored value. A line with its trigger-mode bit set has a request bit that follows the input, and acknowledge does not clear it.
- R4: Within a controller, the lowest-numbered unmasked requesting line wins. It qualifies only if its number is lower than that of every in-service line. int_out is 1 exactly when the master has a qualifying line.
- R5: On acknowledge with a qualifying master line other than 2, vector equals master base plus the line number in the same cycle, and that line's in-service bit is set at the next edge.
- R6: While the slave has a qualifying line, master request bit 2 is set at the next edge as an edge event. The external input irq_in[2] has no effect.
- R7: On acknowledge when master line 2 wins and the slave has a qualifying line, vector equals slave base plus the slave line. In-service bits are set in both controllers.
- R8: On acknowledge with no qualifying master line, vector equals master base plus 7 and no register changes.
- R9: On acknowledge when master line 2 wins and the slave has no qualifying line, vector equals slave base plus 7.
- R10: Writing 0x0C to a command port arms poll. The next read of either port of that controller returns 0x80 OR the winning line, clears that line's request and in-service bits, and disarms poll. With no winner it returns 0x07.
- R11: A poll read of the slave that finds a winner also clears master request and in-service bit 2.
- R12: Writing 0x20 to a command port clears the lowest-numbered in-service bit. Writing 0x60 OR n clears in-service bit n.
- R13: Writing a byte with bit 4 set to a command port clears mask, in-service, edge requests, read select and poll. The next data-port write sets the base (bits 7:3), one further data write is absorbed, and if bit 0 of the command was 1 a fourth write is absorbed as well. After that, data-port writes set the mask. A command-port read returns request bits after command 0x0A and in-service bits after 0x0B, and a data-port read returns the mask.
- R14: Reads from addresses outside 0x20/0x21, 0xA0/0xA1 and 0x4D0/0x4D1 return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Port address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, otherwise 0 |
| ack | input | 1 | Processor acknowledge strobe |
| vector | output | 8 | Vector for the acknowledge, valid in the ack cycle |
| irq_in | input | 16 | Interrupt inputs; bits 7:0 master, 15:8 slave |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong request, in-service or mask bit shows at int_out in the very next cycle, because the output is decoded directly from the master registers. Errors in the slave take one more cycle, through the latch on master line 2. A wrong winner, base or spurious substitution shows in the vector during the acknowledge cycle itself. Stale bits left by an acknowledge, a poll or an end-of-interrupt command show on the first later read of the request or in-service registers, or as a missing or extra int_out assertion in the next cycle. The bench keeps a behavioural model of both controllers and compares int_out, vector and read data on every clock.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NL = 8;
  localparam int unsigned LW = $clog2(NL);

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} init_step_t;

  // Returns {none, index} of the lowest set bit; none=1 when v is zero.
  function automatic logic [LW:0] first_set(input logic [NL-1:0] v);
    logic [LW:0] r;
    r = {1'b1, {LW{1'b0}}};
    for (int i = NL - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b0, LW'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  logic [NL-1:0] irr,
  input  logic [NL-1:0] imr,
  input  logic [NL-1:0] isr,
  output logic          act,
  output logic [LW-1:0] line
);
  logic [LW:0] req_f;
  logic [LW:0] svc_f;

  always_comb begin
    req_f = first_set(irr & ~imr);
    svc_f = first_set(isr);
    // "none" encodes as NL, so an empty in-service set never blocks
    act   = !req_f[LW] && (req_f < svc_f);
    line  = req_f[LW-1:0];
  end
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter logic [NL-1:0] TM_ALLOW = 8'hFF,
  parameter logic [NL-1:0] LINE_USE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] lines,
  input  logic [NL-1:0] set_mask,
  input  logic [NL-1:0] ext_clr,
  input  logic          cmd_wr,
  input  logic          data_wr,
  input  logic          tm_wr,
  input  logic [7:0]    wdata,
  input  logic          ack_take,
  input  logic          poll_take,
  output logic          win_act,
  output logic [LW-1:0] win_line,
  output logic [NL-1:0] irr_o,
  output logic [NL-1:0] isr_o,
  output logic [NL-1:0] imr_o,
  output logic [NL-1:0] tm_o,
  output logic [7:3]    base_o,
  output logic          rsel_o,
  output logic          poll_o
);
  logic [NL-1:0] irr_q, isr_q, imr_q, tm_q, lvl_q;
  logic [NL-1:0] irr_n, isr_n, imr_n, tm_n, lvl_n;
  logic [7:3]    base_q, base_n;
  init_step_t    step_q, step_n;
  logic          need4_q, need4_n, rsel_q, rsel_n, poll_q, poll_n;
  logic [NL-1:0] use_in, irr_smp;
  logic [LW:0]   eoi_f;

  assign use_in = lines & LINE_USE;

  generate
    for (genvar i = 0; i < NL; i++) begin : g_line
      assign irr_smp[i] = set_mask[i] |
                          (tm_q[i] ? use_in[i] : (irr_q[i] | (use_in[i] & ~lvl_q[i])));
    end
  endgenerate

  pic_resolve u_res (
    .irr  (irr_q),
    .imr  (imr_q),
    .isr  (isr_q),
    .act  (win_act),
    .line (win_line)
  );

  always_comb begin
    irr_n   = irr_smp;
    isr_n   = isr_q;
    imr_n   = imr_q;
    tm_n    = tm_q;
    lvl_n   = use_in;
    base_n  = base_q;
    step_n  = step_q;
    need4_n = need4_q;
    rsel_n  = rsel_q;
    poll_n  = poll_q;
    eoi_f   = first_set(isr_q);

    if (ack_take && win_act) begin
      isr_n[win_line] = 1'b1;
      if (!tm_q[win_line]) irr_n[win_line] = 1'b0;
    end
    if (poll_take) begin
      poll_n = 1'b0;
      if (win_act) begin
        irr_n[win_line] = 1'b0;
        isr_n[win_line] = 1'b0;
      end
    end
    irr_n = irr_n & ~ext_clr;
    isr_n = isr_n & ~ext_clr;

    if (cmd_wr) begin
      if (wdata[4]) begin
        irr_n   = irr_n & tm_q;
        isr_n   = '0;
        imr_n   = '0;
        lvl_n   = '0;
        rsel_n  = 1'b0;
        poll_n  = 1'b0;
        step_n  = ST_BASE;
        need4_n = wdata[0];
      end else if (wdata[3]) begin
        if (wdata[2]) poll_n = 1'b1;
        if (wdata[1]) rsel_n = wdata[0];
      end else begin
        case (wdata[7:5])
          3'd1: if (!eoi_f[LW]) isr_n[eoi_f[LW-1:0]] = 1'b0;
          3'd3: isr_n[wdata[LW-1:0]] = 1'b0;
          default: ;
        endcase
      end
    end

    if (data_wr) begin
      case (step_q)
        ST_RUN:  imr_n = wdata;
        ST_BASE: begin
          base_n = wdata[7:3];
          step_n = ST_CASC;
        end
        ST_CASC: step_n = need4_q ? ST_MODE : ST_RUN;
        default: step_n = ST_RUN;
      endcase
    end

    if (tm_wr) tm_n = wdata & TM_ALLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q   <= '0;
      isr_q   <= '0;
      imr_q   <= '0;
      tm_q    <= '0;
      lvl_q   <= '0;
      base_q  <= '0;
      step_q  <= ST_RUN;
      need4_q <= 1'b0;
      rsel_q  <= 1'b0;
      poll_q  <= 1'b0;
    end else begin
      irr_q   <= irr_n;
      isr_q   <= isr_n;
      imr_q   <= imr_n;
      tm_q    <= tm_n;
      lvl_q   <= lvl_n;
      base_q  <= base_n;
      step_q  <= step_n;
      need4_q <= need4_n;
      rsel_q  <= rsel_n;
      poll_q  <= poll_n;
    end
  end

  assign irr_o  = irr_q;
  assign isr_o  = isr_q;
  assign imr_o  = imr_q;
  assign tm_o   = tm_q;
  assign base_o = base_q;
  assign rsel_o = rsel_q;
  assign poll_o = poll_q;

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && win_act && !cmd_wr && !poll_take && ext_clr == '0)
      |=> isr_q[$past(win_line)]) else $error("ack did not set in-service"); // R5

  AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && win_act && !ack_take && !cmd_wr)
      |=> (!isr_q[$past(win_line)] && !irr_q[$past(win_line)])) else $error("poll left line set"); // R10
endmodule

// File: rtl/pic_cascade_unit.sv
module pic_cascade_unit
  import pic_pkg::*;
#(
  parameter int unsigned         ADDR_W     = 12,
  parameter logic [ADDR_W-1:0]   M_PORT     = 'h020,
  parameter logic [ADDR_W-1:0]   S_PORT     = 'h0A0,
  parameter logic [ADDR_W-1:0]   TM_PORT    = 'h4D0,
  parameter int unsigned         CASC       = 2,
  parameter logic [NL-1:0]       M_TM_ALLOW = 8'hF8,
  parameter logic [NL-1:0]       S_TM_ALLOW = 8'hDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              ack,
  output logic [7:0]        vector,
  input  logic [2*NL-1:0]   irq_in,
  output logic              int_out
);
  localparam logic [NL-1:0] CASC_BIT = NL'(1) << CASC;
  localparam logic [NL-1:0] M_USE    = ~CASC_BIT;

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic sel_m, sel_s, sel_tm, odd;
  assign sel_m  = bus_addr[ADDR_W-1:1] == M_PORT[ADDR_W-1:1];
  assign sel_s  = bus_addr[ADDR_W-1:1] == S_PORT[ADDR_W-1:1];
  assign sel_tm = bus_addr[ADDR_W-1:1] == TM_PORT[ADDR_W-1:1];
  assign odd    = bus_addr[0];

  logic          m_act, s_act;
  logic [LW-1:0] m_line, s_line;
  logic [NL-1:0] m_irr, m_isr, m_imr, m_tm, s_irr, s_isr, s_imr, s_tm;
  logic [7:3]    m_base, s_base;
  logic          m_rsel, s_rsel, m_poll, s_poll;
  logic          m_poll_take, s_poll_take, m_ack, s_ack, casc_win;

  assign casc_win    = m_act && (m_line == LW'(CASC));
  assign m_ack       = ack && m_act;
  assign s_ack       = ack && casc_win && s_act;
  assign m_poll_take = bus_rd && sel_m && m_poll;
  assign s_poll_take = bus_rd && sel_s && s_poll;

  pic_core #(.TM_ALLOW(M_TM_ALLOW), .LINE_USE(M_USE)) u_master (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .lines     (irq_in[NL-1:0]),
    .set_mask  (s_act ? CASC_BIT : '0),
    .ext_clr   ((s_poll_take && s_act) ? CASC_BIT : '0),
    .cmd_wr    (bus_wr && sel_m && !odd),
    .data_wr   (bus_wr && sel_m && odd),
    .tm_wr     (bus_wr && sel_tm && !odd),
    .wdata     (bus_wdata),
    .ack_take  (m_ack),
    .poll_take (m_poll_take),
    .win_act   (m_act),
    .win_line  (m_line),
    .irr_o     (m_irr),
    .isr_o     (m_isr),
    .imr_o     (m_imr),
    .tm_o      (m_tm),
    .base_o    (m_base),
    .rsel_o    (m_rsel),
    .poll_o    (m_poll)
  );

  pic_core #(.TM_ALLOW(S_TM_ALLOW), .LINE_USE({NL{1'b1}})) u_slave (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .lines     (irq_in[2*NL-1:NL]),
    .set_mask  ('0),
    .ext_clr   ('0),
    .cmd_wr    (bus_wr && sel_s && !odd),
    .data_wr   (bus_wr && sel_s && odd),
    .tm_wr     (bus_wr && sel_tm && odd),
    .wdata     (bus_wdata),
    .ack_take  (s_ack),
    .poll_take (s_poll_take),
    .win_act   (s_act),
    .win_line  (s_line),
    .irr_o     (s_irr),
    .isr_o     (s_isr),
    .imr_o     (s_imr),
    .tm_o      (s_tm),
    .base_o    (s_base),
    .rsel_o    (s_rsel),
    .poll_o    (s_poll)
  );

  always_comb begin
    if (!m_act)        vector = {m_base, 3'd7};
    else if (casc_win) vector = {s_base, s_act ? s_line : 3'd7};
    else               vector = {m_base, m_line};
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_m) begin
        if (m_poll)   bus_rdata = m_act ? {5'b10000, m_line} : 8'h07;
        else if (odd) bus_rdata = m_imr;
        else          bus_rdata = m_rsel ? m_isr : m_irr;
      end else if (sel_s) begin
        if (s_poll)   bus_rdata = s_act ? {5'b10000, s_line} : 8'h07;
        else if (odd) bus_rdata = s_imr;
        else          bus_rdata = s_rsel ? s_isr : s_irr;
      end else if (sel_tm) begin
        bus_rdata = odd ? s_tm : m_tm;
      end
    end
  end

  assign int_out = m_act;

  AST_SPURIOUS_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ack && !m_act && !bus_wr && !bus_rd) |=> ($stable(m_isr) && $stable(s_isr)))
    else $error("spurious ack changed in-service"); // R8

  AST_CASCADE_LATCH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (s_act && !ack && !bus_wr && !bus_rd) |=> m_irr[CASC])
    else $error("slave request not latched on master"); // R6
endmodule

// File: tb/pic_cascade_unit_tb.sv
`timescale 1ns/1ps
module pic_cascade_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd, ack;
  logic [7:0]  bus_rdata, vector;
  logic [15:0] irq_in;
  logic        int_out;

  always #2.5 clk = ~clk;

  pic_cascade_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ack(ack),
    .vector(vector), .irq_in(irq_in), .int_out(int_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [7:0] last_rd, last_vec;
  logic last_int;

  // behavioural model state, index 0 master, 1 slave
  bit [7:0] m_irr[2], m_isr[2], m_imr[2], m_tm[2], m_lvl[2];
  bit [7:0] m_base[2];
  int       m_step[2];
  bit       m_need4[2], m_rsel[2], m_poll[2];
  bit [7:0] tm_allow[2] = '{8'hF8, 8'hDE};

  function automatic int win(int c);
    bit [7:0] req = m_irr[c] & ~m_imr[c];
    int p = 8, q = 8;
    for (int b = 7; b >= 0; b--) begin
      if (req[b]) p = b;
      if (m_isr[c][b]) q = b;
    end
    return (p < q) ? p : -1;
  endfunction

  function automatic int which(logic [11:0] a);
    if (a == 12'h020 || a == 12'h021) return 0;
    if (a == 12'h0A0 || a == 12'h0A1) return 1;
    if (a == 12'h4D0 || a == 12'h4D1) return 2;
    return -1;
  endfunction

  function automatic logic [7:0] exp_vec(int mw, int sw);
    if (mw < 0) return m_base[0] + 8'd7;
    if (mw == 2) return m_base[1] + ((sw < 0) ? 8'd7 : 8'(sw));
    return m_base[0] + 8'(mw);
  endfunction

  function automatic logic [7:0] exp_rd(logic [11:0] a, int mw, int sw);
    int c = which(a);
    int w;
    if (c == 2) return m_tm[a[0]];
    if (c < 0) return 8'h00;
    w = (c == 0) ? mw : sw;
    if (m_poll[c]) return (w >= 0) ? (8'h80 | 8'(w)) : 8'h07;
    if (a[0]) return m_imr[c];
    return m_rsel[c] ? m_isr[c] : m_irr[c];
  endfunction

  task automatic cmp(string req, string what, logic [7:0] a, logic [7:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, a, e);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_irr[c] = 0; m_isr[c] = 0; m_imr[c] = 0; m_tm[c] = 0; m_lvl[c] = 0;
      m_base[c] = 0; m_step[c] = 0; m_need4[c] = 0; m_rsel[c] = 0; m_poll[c] = 0;
    end
  endtask

  task automatic model_step(int mw, int sw);
    int c;
    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < 8; b++) begin
        bit inb = irq_in[k*8+b];
        if (k == 0 && b == 2) inb = 0;
        if (m_tm[k][b]) m_irr[k][b] = inb;
        else if (inb && !m_lvl[k][b]) m_irr[k][b] = 1;
        m_lvl[k][b] = inb;
      end
    end
    if (sw >= 0) m_irr[0][2] = 1;
    if (ack && mw >= 0) begin
      m_isr[0][mw] = 1;
      if (!m_tm[0][mw]) m_irr[0][mw] = 0;
      if (mw == 2 && sw >= 0) begin
        m_isr[1][sw] = 1;
        if (!m_tm[1][sw]) m_irr[1][sw] = 0;
      end
    end
    c = which(bus_addr);
    if (bus_rd && (c == 0 || c == 1) && m_poll[c]) begin
      int w = (c == 0) ? mw : sw;
      m_poll[c] = 0;
      if (w >= 0) begin
        m_irr[c][w] = 0; m_isr[c][w] = 0;
        if (c == 1) begin m_irr[0][2] = 0; m_isr[0][2] = 0; end
      end
    end
    if (bus_wr && c == 2) m_tm[bus_addr[0]] = bus_wdata & tm_allow[bus_addr[0]];
    if (bus_wr && (c == 0 || c == 1)) begin
      if (!bus_addr[0]) begin
        if (bus_wdata[4]) begin
          m_irr[c] &= m_tm[c]; m_isr[c] = 0; m_imr[c] = 0; m_lvl[c] = 0;
          m_rsel[c] = 0; m_poll[c] = 0; m_step[c] = 1; m_need4[c] = bus_wdata[0];
        end else if (bus_wdata[3]) begin
          if (bus_wdata[2]) m_poll[c] = 1;
          if (bus_wdata[1]) m_rsel[c] = bus_wdata[0];
        end else if (bus_wdata[7:5] == 3'd1) begin
          for (int b = 7; b >= 0; b--) if (m_isr[c][b]) c = c;
          begin
            int lo = -1;
            for (int b = 7; b >= 0; b--) if (m_isr[c][b]) lo = b;
            if (lo >= 0) m_isr[c][lo] = 0;
          end
        end else if (bus_wdata[7:5] == 3'd3) begin
          m_isr[c][bus_wdata[2:0]] = 0;
        end
      end else begin
        case (m_step[c])
          0: m_imr[c] = bus_wdata;
          1: begin m_base[c] = bus_wdata & 8'hF8; m_step[c] = 2; end
          2: m_step[c] = m_need4[c] ? 3 : 0;
          default: m_step[c] = 0;
        endcase
      end
    end
  endtask

  task automatic cyc();
    int mw, sw;
    #1;
    mw = win(0); sw = win(1);
    last_int = int_out;
    cmp(cur_req, "int_out(R4)", {7'd0, int_out}, {7'd0, (mw >= 0)});
    if (ack) begin
      last_vec = vector;
      cmp(cur_req, "vector", vector, exp_vec(mw, sw));
    end
    if (bus_rd) begin
      last_rd = bus_rdata;
      cmp(cur_req, "rdata", bus_rdata, exp_rd(bus_addr, mw, sw));
    end
    @(posedge clk);
    model_step(mw, sw);
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; cyc(); bus_wr = 0; bus_addr = 0;
  endtask
  task automatic rd(logic [11:0] a);
    bus_addr = a; bus_rd = 1; cyc(); bus_rd = 0; bus_addr = 0;
  endtask
  task automatic ak();
    ack = 1; cyc(); ack = 0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0; ack = 0; irq_in = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);

    cur_req = "R1";
    rd(12'h020); cmp("R1", "m irr", last_rd, 8'h00);
    rd(12'h021); cmp("R1", "m imr", last_rd, 8'h00);
    rd(12'h0A0); cmp("R1", "s irr", last_rd, 8'h00);
    rd(12'h4D1); cmp("R1", "s tm", last_rd, 8'h00);
    cmp("R1", "int_out", {7'd0, last_int}, 8'h00);

    cur_req = "R13";
    wr(12'h021, 8'h5A); rd(12'h021); cmp("R13", "imr pre-init", last_rd, 8'h5A);
    wr(12'h020, 8'h11); rd(12'h021); cmp("R13", "imr cleared", last_rd, 8'h00);
    wr(12'h021, 8'h08); wr(12'h021, 8'h04); wr(12'h021, 8'h01);
    wr(12'h0A0, 8'h11); wr(12'h0A1, 8'h70); wr(12'h0A1, 8'h02); wr(12'h0A1, 8'h01);
    rd(12'h021); cmp("R13", "imr after init", last_rd, 8'h00);

    cur_req = "R5";
    irq_in[1] = 1; idle(2); cmp("R4", "int_out", {7'd0, last_int}, 8'h01);
    ak(); cmp("R5", "vector line1", last_vec, 8'h09);
    cur_req = "R2";
    rd(12'h020); cmp("R2", "edge irr cleared", last_rd, 8'h00);
    idle(2); rd(12'h020); cmp("R2", "held high no relatch", last_rd, 8'h00);
    wr(12'h020, 8'h0B); rd(12'h020); cmp("R13", "isr select", last_rd, 8'h02);
    cur_req = "R12";
    wr(12'h020, 8'h20); rd(12'h020); cmp("R12", "eoi isr", last_rd, 8'h00);
    irq_in[1] = 0;

    cur_req = "R4";
    irq_in[3] = 1; irq_in[5] = 1; idle(2);
    ak(); cmp("R4", "vector prio", last_vec, 8'h0B);
    idle(1); cmp("R4", "blocked by isr", {7'd0, last_int}, 8'h00);
    irq_in[0] = 1; idle(2); cmp("R4", "nested higher", {7'd0, last_int}, 8'h01);
    ak(); cmp("R5", "vector line0", last_vec, 8'h08);
    cur_req = "R12";
    wr(12'h020, 8'h20); rd(12'h020); cmp("R12", "nonspecific lowest", last_rd, 8'h08);
    wr(12'h020, 8'h63); rd(12'h020); cmp("R12", "specific eoi", last_rd, 8'h00);
    ak(); cmp("R4", "vector line5", last_vec, 8'h0D);
    wr(12'h020, 8'h20);
    irq_in[0] = 0; irq_in[3] = 0; irq_in[5] = 0;

    cur_req = "R6";
    wr(12'h020, 8'h0A);
    irq_in[10] = 1; idle(3);
    rd(12'h020); cmp("R6", "master line2 latched", last_rd, 8'h04);
    cur_req = "R7";
    ak(); cmp("R7", "cascade vector", last_vec, 8'h72);
    wr(12'h0A0, 8'h0B); rd(12'h0A0); cmp("R7", "slave isr", last_rd, 8'h04);
    wr(12'h0A0, 8'h20); wr(12'h020, 8'h20);
    irq_in[10] = 0; idle(1);

    cur_req = "R8";
    ak(); cmp("R8", "spurious master", last_vec, 8'h0F);
    wr(12'h020, 8'h0B); rd(12'h020); cmp("R8", "isr unchanged", last_rd, 8'h00);
    wr(12'h020, 8'h0A);

    cur_req = "R9";
    irq_in[9] = 1; idle(3);
    wr(12'h0A1, 8'h02); idle(1);
    ak(); cmp("R9", "spurious slave", last_vec, 8'h77);
    wr(12'h020, 8'h20);
    wr(12'h0A1, 8'h00); idle(2);
    cur_req = "R10";
    wr(12'h0A0, 8'h0C); rd(12'h0A0); cmp("R10", "slave poll byte", last_rd, 8'h81);
    cur_req = "R11";
    idle(1); rd(12'h020); cmp("R11", "master line2 cleared", last_rd, 8'h00);
    irq_in[9] = 0;

    cur_req = "R10";
    wr(12'h020, 8'h0C); rd(12'h020); cmp("R10", "empty poll", last_rd, 8'h07);
    irq_in[4] = 1; idle(2);
    wr(12'h020, 8'h0C); rd(12'h020); cmp("R10", "poll byte", last_rd, 8'h84);
    idle(1); cmp("R10", "poll took line", {7'd0, last_int}, 8'h00);
    rd(12'h020); cmp("R10", "poll disarmed", last_rd, 8'h00);
    irq_in[4] = 0;

    cur_req = "R3";
    wr(12'h4D0, 8'hFF); rd(12'h4D0); cmp("R3", "master tm mask", last_rd, 8'hF8);
    wr(12'h4D1, 8'hFF); rd(12'h4D1); cmp("R3", "slave tm mask", last_rd, 8'hDE);
    irq_in[3] = 1; idle(1);
    ak(); cmp("R3", "level vector", last_vec, 8'h0B);
    rd(12'h020); cmp("R3", "level irr kept", last_rd, 8'h08);
    irq_in[3] = 0; idle(1);
    rd(12'h020); cmp("R3", "level irr follows", last_rd, 8'h00);
    wr(12'h020, 8'h20); wr(12'h4D0, 8'h00); wr(12'h4D1, 8'h00);

    cur_req = "R14";
    wr(12'h022, 8'h55); wr(12'h4D2, 8'h55);
    rd(12'h022); cmp("R14", "unmapped read", last_rd, 8'h00);
    rd(12'h4D2); cmp("R14", "unmapped read tm", last_rd, 8'h00);
    rd(12'h021); cmp("R14", "imr untouched", last_rd, 8'h00);
    rd(12'h4D0); cmp("R14", "tm untouched", last_rd, 8'h00);

    cur_req = "R4";
    wr(12'h021, 8'h40); irq_in[6] = 1; idle(2);
    cmp("R4", "masked line", {7'd0, last_int}, 8'h00);
    wr(12'h021, 8'h00); idle(1); cmp("R4", "unmasked line", {7'd0, last_int}, 8'h01);
    ak(); cmp("R5", "vector line6", last_vec, 8'h0E);
    wr(12'h020, 8'h20); irq_in[6] = 0;

    cur_req = "R6";
    irq_in[2] = 1; idle(2); cmp("R6", "input 2 ignored", {7'd0, last_int}, 8'h00);
    irq_in[2] = 0; idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule